// File: doc/BRIEF.md
# S/PDIF Receive Subframe Controller

This block sits behind a biphase-mark decoder and clock-recovery front end. Each cycle it may be handed one decoded subframe: a two-bit preamble code and the 28 payload bits that follow the preamble (24 audio bits, then validity, user, channel-status and parity). The block works out which channel each subframe belongs to. It counts subframes and frames across a 192-frame block and checks that every preamble is in the place the counters predict. It also checks even parity. It keeps the latest audio word for each channel and shifts the channel-status and user bits of channel 1 into two history registers.

Software reaches the block through a small word-addressed register port. The port has a control word (enable, interrupt enables, request enable), a status word, both audio words, the two bit histories and a counter view. One interrupt line and one data-request line leave the block. Clearing the enable bit puts the receiver into an idle mode. Idle mode zeroes the status and the counters but leaves every data register untouched.

Top module: `spdif_rx_ctrl`

## Requirements
- R1: After reset the status word (address 1) reads 0x01 (bit 0 = idle), the counter word (address 6) reads 0, and both irq and dreq are low.
- R2: Writing 0 to control bit 0 returns the block to idle. The status word then reads 0x01 (sync bit 6 = 0), the counter word reads 0, and the audio, channel-status and user registers keep their contents.
- R3: While idle, incoming subframes are ignored. No data register, status bit or counter changes.
- R4: Preamble code 0 (block start) and code 1 (channel 1) store sf_data[23:0] in the channel-1 word (address 2) and set status bit 1. Code 2 (channel 2) stores into the channel-2 word (address 3) and sets status bit 2. Status bit 6 reads 1 after a channel-1 subframe and 0 after a channel-2 subframe.
- R5: The counter word holds the frame index in bits [23:16] and the subframe index in bits [8:0]. A channel-2 subframe advances the frame index, which wraps from 191 to 0. The subframe index counts modulo 384. Code 0 sets the frame index to 0 and the subframe index to 1.
- R6: The expected preamble is code 0 when status bit 6 is 0 and the frame index is 0, code 1 when bit 6 is 0 and the frame index is not 0, and code 2 when bit 6 is 1. Any other code sets status bit 4. Code 3 (no preamble) also sets bit 4, and its subframe is dropped without moving the counters.
- R7: Parity is even over all 28 sf_data bits (bit 27 is the parity bit). A subframe with odd parity sets status bit 5.
- R8: A subframe arriving for a channel whose ready bit is still set overwrites that channel's word and sets status bit 3.
- R9: Reading address 2 or 3 clears ready bit 1 or 2. Writing 1 to any of status bits 1 to 5 clears that bit.
- R10: irq is high when any status bit k in 0..5 is set together with control bit k+1.
- R11: dreq equals control bit 7 AND control bit 0 AND (status bit 1 OR status bit 2). Reading the channel-status or user register never affects dreq.
- R12: Each accepted channel-1 subframe shifts sf_data[26] into bit 0 of the channel-status register (address 4) and sf_data[25] into bit 0 of the user register (address 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sf_valid | input | 1 | A decoded subframe is present this cycle |
| sf_pre | input | 2 | Preamble code: 0 block start, 1 channel 1, 2 channel 2, 3 none |
| sf_data | input | 28 | Subframe payload: audio [23:0], V [24], U [25], C [26], P [27] |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on data reads) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| irq | output | 1 | Receive interrupt |
| dreq | output | 1 | Receive data request |

## Verification
The embedded properties check, on every cycle, that the counters stay in range and are zero during idle, and that the data registers hold still during idle. They also check that the sync indicator follows the channel of each accepted subframe, that parity faults and overruns set their flags on the next cycle, and that dreq stays low while idle. The bench scenarios show what no single-cycle property can: that a whole 192-frame block lines up so the next block-start preamble is accepted without error, that preamble resynchronisation moves the counters as specified, and that the bit histories build up in order. They also show that idle keeps earlier audio words and that register reads and write-one-to-clear steps interact correctly with new arrivals.

// File: rtl/spdif_rx_pkg.sv
package spdif_rx_pkg;

    localparam int SF_W   = 28;
    localparam int AUD_W  = 24;
    localparam int BIT_U  = 25;
    localparam int BIT_C  = 26;
    localparam int STAT_W = 7;
    localparam int HIST_W = 32;

    typedef enum logic [1:0] {
        PRE_BLK  = 2'd0,
        PRE_CH1  = 2'd1,
        PRE_CH2  = 2'd2,
        PRE_LOST = 2'd3
    } pre_e;

    typedef struct packed {
        logic sync;
        logic par_err;
        logic pre_err;
        logic ovr;
        logic rdy2;
        logic rdy1;
        logic idle;
    } rx_stat_t;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_AUD1 = 3'd2;
    localparam logic [2:0] A_AUD2 = 3'd3;
    localparam logic [2:0] A_CSH  = 3'd4;
    localparam logic [2:0] A_USH  = 3'd5;
    localparam logic [2:0] A_CNT  = 3'd6;

    function automatic logic parity_bad(input logic [SF_W-1:0] d);
        return ^d;
    endfunction

    function automatic pre_e next_pre(input logic sync, input logic at_start);
        if (sync)          return PRE_CH2;
        else if (at_start) return PRE_BLK;
        else               return PRE_CH1;
    endfunction

endpackage

// File: rtl/spdif_rx_track.sv
module spdif_rx_track
    import spdif_rx_pkg::*;
#(
    parameter int FRAMES = 192,
    localparam int WORDS = 2 * FRAMES,
    localparam int FW    = $clog2(FRAMES),
    localparam int WW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          sf_valid,
    input  logic [1:0]    sf_pre,
    output logic          take,
    output logic          is_ch2,
    output logic          pre_bad,
    output logic          sync,
    output logic [FW-1:0] fcnt,
    output logic [WW-1:0] wcnt
);

    pre_e pre_in;
    pre_e pre_exp;
    logic hit;

    assign pre_in  = pre_e'(sf_pre);
    assign pre_exp = next_pre(sync, fcnt == '0);
    assign hit     = en && sf_valid;
    assign take    = hit && (pre_in != PRE_LOST);
    assign is_ch2  = (pre_in == PRE_CH2);
    assign pre_bad = hit && (pre_in != pre_exp);

    function automatic logic [WW-1:0] wnext(input logic [WW-1:0] w);
        return (w == WW'(WORDS - 1)) ? '0 : w + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            fcnt <= '0;
            wcnt <= '0;
            sync <= 1'b0;
        end else if (take) begin
            unique case (pre_in)
                PRE_BLK: begin
                    fcnt <= '0;
                    wcnt <= WW'(1);
                    sync <= 1'b1;
                end
                PRE_CH1: begin
                    wcnt <= wnext(wcnt);
                    sync <= 1'b1;
                end
                default: begin
                    fcnt <= (fcnt == FW'(FRAMES - 1)) ? '0 : fcnt + 1'b1;
                    wcnt <= wnext(wcnt);
                    sync <= 1'b0;
                end
            endcase
        end
    end

    // R5
    frame_range_chk: assert property (@(posedge clk) disable iff (rst)
        (fcnt < FW'(FRAMES)) && (wcnt < WW'(WORDS)));

    // R2
    idle_counters_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (fcnt == '0) && (wcnt == '0) && !sync);

    // R4
    sync_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (take && en) |=> (sync == !$past(is_ch2)) || !en);

endmodule

// File: rtl/spdif_rx_store.sv
module spdif_rx_store
    import spdif_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              take,
    input  logic              is_ch2,
    input  logic              pre_bad,
    input  logic              sync,
    input  logic [SF_W-1:0]   sf_data,
    input  logic              rd1,
    input  logic              rd2,
    input  logic [STAT_W-1:0] w1c,
    output rx_stat_t          stat,
    output logic [AUD_W-1:0]  aud1,
    output logic [AUD_W-1:0]  aud2,
    output logic [HIST_W-1:0] csh,
    output logic [HIST_W-1:0] ush
);

    logic rdy1, rdy2, ovr, pre_err, par_err;
    logic clr1, clr2, take1, take2;

    assign clr1  = rd1 || w1c[1];
    assign clr2  = rd2 || w1c[2];
    assign take1 = take && !is_ch2;
    assign take2 = take && is_ch2;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            rdy1    <= 1'b0;
            rdy2    <= 1'b0;
            ovr     <= 1'b0;
            pre_err <= 1'b0;
            par_err <= 1'b0;
        end else begin
            if (take1)     rdy1 <= 1'b1;
            else if (clr1) rdy1 <= 1'b0;
            if (take2)     rdy2 <= 1'b1;
            else if (clr2) rdy2 <= 1'b0;
            if ((take1 && rdy1 && !clr1) || (take2 && rdy2 && !clr2)) ovr <= 1'b1;
            else if (w1c[3]) ovr <= 1'b0;
            if (pre_bad)     pre_err <= 1'b1;
            else if (w1c[4]) pre_err <= 1'b0;
            if (take && parity_bad(sf_data)) par_err <= 1'b1;
            else if (w1c[5])                 par_err <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aud1 <= '0;
            aud2 <= '0;
            csh  <= '0;
            ush  <= '0;
        end else begin
            if (take1) begin
                aud1 <= sf_data[AUD_W-1:0];
                csh  <= {csh[HIST_W-2:0], sf_data[BIT_C]};
                ush  <= {ush[HIST_W-2:0], sf_data[BIT_U]};
            end
            if (take2) aud2 <= sf_data[AUD_W-1:0];
        end
    end

    always_comb begin
        if (en) stat = '{sync: sync, par_err: par_err, pre_err: pre_err, ovr: ovr,
                          rdy2: rdy2, rdy1: rdy1, idle: 1'b0};
        else    stat = '{idle: 1'b1, default: 1'b0};
    end

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (en && take1 && rdy1 && !clr1) |=> (ovr || !en));

    // R7
    parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (en && take && parity_bad(sf_data)) |=> (par_err || !en));

    // R2
    idle_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !take) |=> $stable(aud1) && $stable(aud2) && $stable(csh) && $stable(ush));

endmodule

// File: rtl/spdif_rx_ctrl.sv
module spdif_rx_ctrl
    import spdif_rx_pkg::*;
#(
    parameter int FRAMES = 192,
    localparam int FW    = $clog2(FRAMES),
    localparam int WW    = $clog2(2 * FRAMES)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sf_valid,
    input  logic [1:0]  sf_pre,
    input  logic [27:0] sf_data,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        dreq
);

    logic [7:0]        ctrl;
    logic              en;
    logic              take, is_ch2, pre_bad, sync;
    logic [FW-1:0]     fcnt;
    logic [WW-1:0]     wcnt;
    logic [STAT_W-1:0] w1c;
    logic              rd1, rd2;
    rx_stat_t          stat;
    logic [AUD_W-1:0]  aud1, aud2;
    logic [HIST_W-1:0] csh, ush;
    logic [STAT_W-1:0] stat_v;

    assign en     = ctrl[0];
    assign stat_v = stat;
    assign w1c    = (reg_wr && reg_addr == A_STAT) ? reg_wdata[STAT_W-1:0] : '0;
    assign rd1    = reg_rd && (reg_addr == A_AUD1);
    assign rd2    = reg_rd && (reg_addr == A_AUD2);

    always_ff @(posedge clk) begin
        if (rst)                              ctrl <= '0;
        else if (reg_wr && reg_addr == A_CTRL) ctrl <= reg_wdata[7:0];
    end

    spdif_rx_track #(.FRAMES(FRAMES)) u_track (
        .clk(clk), .rst(rst), .en(en), .sf_valid(sf_valid), .sf_pre(sf_pre),
        .take(take), .is_ch2(is_ch2), .pre_bad(pre_bad), .sync(sync),
        .fcnt(fcnt), .wcnt(wcnt)
    );

    spdif_rx_store u_store (
        .clk(clk), .rst(rst), .en(en), .take(take), .is_ch2(is_ch2),
        .pre_bad(pre_bad), .sync(sync), .sf_data(sf_data), .rd1(rd1), .rd2(rd2),
        .w1c(w1c), .stat(stat), .aud1(aud1), .aud2(aud2), .csh(csh), .ush(ush)
    );

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = 32'(ctrl);
            A_STAT:  reg_rdata = 32'(stat_v);
            A_AUD1:  reg_rdata = 32'(aud1);
            A_AUD2:  reg_rdata = 32'(aud2);
            A_CSH:   reg_rdata = 32'(csh);
            A_USH:   reg_rdata = 32'(ush);
            A_CNT:   reg_rdata = (32'(fcnt) << 16) | 32'(wcnt);
            default: reg_rdata = '0;
        endcase
    end

    assign irq  = |(stat_v[5:0] & ctrl[6:1]);
    assign dreq = ctrl[7] && en && (stat.rdy1 || stat.rdy2);

    // R11
    dreq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl[0] |-> !dreq);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat_v == 7'h01) && !irq);

endmodule

// File: tb/test_spdif_rx_ctrl.sv
module test_spdif_rx_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        sf_valid;
    logic [1:0]  sf_pre;
    logic [27:0] sf_data;
    logic        reg_wr, reg_rd;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq, dreq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    spdif_rx_ctrl i_spdif_rx_ctrl (
        .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_pre(sf_pre), .sf_data(sf_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .dreq(dreq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] pre, input logic [23:0] aud,
                        input logic c, input logic u, input logic badp);
        logic p;
        p = (^{c, u, 1'b0, aud}) ^ badp;
        sf_valid = 1'b1;
        sf_pre   = pre;
        sf_data  = {p, c, u, 1'b0, aud};
        @(negedge clk);
        sf_valid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1, v); chk("R1 status", v, 32'h01);
        rd(6, v); chk("R1 counters", v, 0);
        chk("R1 irq/dreq", {irq, dreq}, 0);
    endtask

    task automatic t_idle_ignore();
        logic [31:0] v;
        send(0, 24'h5A5A5A, 1, 1, 0);
        rd(1, v); chk("R3 status", v, 32'h01);
        rd(2, v); chk("R3 data", v, 0);
        rd(6, v); chk("R3 counters", v, 0);
    endtask

    task automatic t_route();
        logic [31:0] v;
        wr(0, 32'h01);
        rd(1, v); chk("R1 enabled status", v, 32'h00);
        send(0, 24'h123456, 0, 0, 0);
        rd(1, v); chk("R4 ch1 ready+sync", v, 32'h42);
        rd(2, v); chk("R4 ch1 word", v, 32'h123456);
        rd(1, v); chk("R9 read clears ready1", v, 32'h40);
        send(2, 24'hABCDEF, 0, 0, 0);
        rd(1, v); chk("R4 ch2 ready", v, 32'h04);
        rd(6, v); chk("R5 after frame 0", v, 32'h00010002);
        rd(3, v); chk("R4 ch2 word", v, 32'hABCDEF);
        rd(1, v); chk("R9 read clears ready2", v, 32'h00);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        send(1, 24'h000111, 0, 0, 0);
        rd(1, v); chk("R4 M ready", v, 32'h42);
        send(2, 24'h000333, 0, 0, 0);
        rd(1, v); chk("R4 both ready", v, 32'h06);
        send(1, 24'h000222, 0, 0, 0);
        rd(1, v); chk("R8 overrun flag", v, 32'h4E);
        rd(2, v); chk("R8 overwritten word", v, 32'h000222);
        wr(1, 32'h0E);
        rd(1, v); chk("R9 w1c", v, 32'h40);
        send(2, 24'h000444, 0, 0, 0);
        rd(6, v); chk("R5 after frame 2", v, 32'h00030006);
    endtask

    task automatic t_preamble();
        logic [31:0] v;
        send(2, 24'h000555, 0, 0, 0);
        rd(1, v); chk("R6 W where M expected", v, 32'h1C);
        rd(6, v); chk("R5 count after W", v, 32'h00040007);
        send(3, 24'h000666, 0, 0, 0);
        rd(6, v); chk("R6 lost preamble keeps counters", v, 32'h00040007);
        rd(3, v); chk("R6 lost subframe dropped", v, 32'h000555);
        wr(1, 32'h3E);
        rd(1, v); chk("R9 w1c all", v, 32'h00);
        send(0, 24'h000000, 0, 0, 0);
        rd(1, v); chk("R6 B mid-block", v, 32'h52);
        rd(6, v); chk("R5 B resync", v, 32'h00000001);
        send(2, 24'h000000, 0, 0, 0);
        wr(1, 32'h3E);
    endtask

    task automatic t_parity();
        logic [31:0] v;
        send(1, 24'h0F0F0F, 0, 0, 1);
        rd(1, v); chk("R7 parity error", v, 32'h62);
        wr(1, 32'h3E);
        rd(1, v); chk("R7 cleared", v, 32'h40);
    endtask

    task automatic t_idle_enter();
        logic [31:0] v;
        wr(0, 32'h00);
        rd(1, v); chk("R2 idle status", v, 32'h01);
        rd(6, v); chk("R2 idle counters", v, 0);
        rd(2, v); chk("R2 ch1 word kept", v, 32'h0F0F0F);
    endtask

    task automatic t_history();
        logic [31:0] v;
        wr(0, 32'h01);
        send(0, 24'h1, 1, 0, 0); send(2, 24'h2, 0, 0, 0);
        send(1, 24'h3, 0, 1, 0); send(2, 24'h4, 0, 0, 0);
        send(1, 24'h5, 1, 1, 0); send(2, 24'h6, 0, 0, 0);
        send(1, 24'h7, 1, 0, 0); send(2, 24'h8, 0, 0, 0);
        rd(4, v); chk("R12 channel-status history", v, 32'hB);
        rd(5, v); chk("R12 user history", v, 32'h6);
        wr(1, 32'h3E);
        wr(0, 32'h81);
        rd(4, v); chk("R11 history read no dreq", {31'd0, dreq}, 0);
        wr(0, 32'h00);
        rd(4, v); chk("R2 history kept", v, 32'hB);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(0, 32'h01);
        for (int f = 0; f < 191; f++) begin
            send((f == 0) ? 2'd0 : 2'd1, 24'(f), 0, 0, 0);
            send(2, 24'(f), 0, 0, 0);
        end
        rd(6, v); chk("R5 frame 191", v, 32'h00BF017E);
        send(1, 24'h0, 0, 0, 0);
        send(2, 24'h0, 0, 0, 0);
        rd(6, v); chk("R5 wrap to 0", v, 0);
        send(0, 24'h0, 0, 0, 0);
        rd(1, v); chk("R6 block start accepted", v & 32'h30, 0);
        rd(6, v); chk("R5 new block", v, 32'h00000001);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(1, 32'h3E);
        wr(0, 32'h21);
        chk("R10 irq quiet", {31'd0, irq}, 0);
        send(1, 24'h0, 0, 0, 0);
        chk("R10 irq on preamble error", {31'd0, irq}, 1);
        wr(1, 32'h10);
        chk("R10 irq cleared", {31'd0, irq}, 0);
        wr(0, 32'h02);
        chk("R10 irq on idle", {31'd0, irq}, 1);
    endtask

    task automatic t_dreq();
        logic [31:0] v;
        wr(0, 32'h81);
        chk("R11 dreq low", {31'd0, dreq}, 0);
        send(0, 24'h77, 0, 0, 0);
        chk("R11 dreq on ready", {31'd0, dreq}, 1);
        rd(2, v);
        chk("R11 dreq after read", {31'd0, dreq}, 0);
    endtask

    initial begin
        rst = 1'b1; sf_valid = 0; sf_pre = 0; sf_data = 0;
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_ignore();
        t_route();
        t_overrun();
        t_preamble();
        t_parity();
        t_idle_enter();
        t_history();
        t_wrap();
        t_irq();
        t_dreq();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule